// File: doc/BRIEF.md
# Streaming Write Allocation Mode Detector

This block sits beside the miss handling of a cache. It watches the cacheable write requests that miss and decides whether they form one sequential stream. A write is sequential when it starts at the byte just past the end of the previous observed write. While a stream continues, the block adds up its bytes. Past a lower limit it asks the miss logic to coalesce writes. Past a higher limit it also tells the fill path not to allocate lines that are written whole.

The block also keeps a small table of delay credits, one entry per recently streamed line. The miss queue sends a query for a line when it is about to issue a write that does not cover the whole line. While coalescing is on and that line still has credit, the block answers "hold", together with a suggested hold length in cycles. Each such answer uses up one credit. A query that finds no credit drops the detector back to normal allocation. A query for a whole-line write clears that line's credit.

A reset-request input returns the stream state to its initial values without touching the credit table.

Top module: `write_stream_detector`

## Requirements
- R1: After the synchronous reset, the mode is allocate (code 0), `coalesce` is 0, `allocate` is 1, the byte count and the next-address register are 0, and the credit table is empty.
- R2: An accepted update is contiguous when `upd_addr` equals the next-address register. After every accepted update, the next-address register becomes `upd_addr + upd_size`, taken modulo 2^ADDR_W. A non-contiguous update reloads the byte count with `upd_size` and sets the mode to allocate.
- R3: On a contiguous update the new byte count is compared strictly against two limits. In allocate mode, a count greater than COAL_LIMIT moves the mode to coalesce (code 1). In coalesce mode, a count greater than NOALLOC_LIMIT moves it to no-allocate (code 2). Each update takes at most one step.
- R4: In no-allocate mode a contiguous update leaves the byte count unchanged. Below that mode the count grows by `upd_size` and saturates at its maximum.
- R5: `mode_o` carries the mode code (0, 1 or 2; code 3 never occurs). `coalesce` is 1 in modes 1 and 2. `allocate` is 0 only in mode 2.
- R6: A contiguous update loads the credit of line `upd_addr >> log2(LINE_BYTES)` with DELAY_THRESH. It creates an entry for that line if none exists. A non-contiguous update sets that line's credit to 0 if the line has an entry.
- R7: `qry_hold` is 1 when all of these hold: `qry_valid` is 1, `qry_full_line` is 0, coalescing is on, and `qry_line` has a nonzero credit. Each such query lowers that credit by one. `qry_hold_cycles` equals LINE_BYTES / `qry_size`, or LINE_BYTES when the size is 0.
- R8: A query for a partial line made while coalescing, when the line has no credit or no entry, returns the mode to allocate and clears the byte count and the next-address register.
- R9: A query with `qry_full_line` = 1 made while coalescing sets that line's credit to 0 and leaves the mode unchanged.
- R10: An update with `upd_is_write` = 0 or `upd_uncacheable` = 1 changes nothing.
- R11: `mode_reset_req` has the highest precedence. It clears the mode, the count and the next address, forces `qry_hold` low, and drops any query or update in that cycle. Otherwise, a cycle with `qry_valid` = 1 drops any update in that cycle, and a query made while not coalescing changes nothing.
- R12: The credit table holds TBL_DEPTH entries. Creating an entry when the table is full replaces the entry that was created earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reset_req | input | 1 | Return stream state to allocate mode |
| upd_valid | input | 1 | A missing request is presented for classification |
| upd_is_write | input | 1 | The request is a write |
| upd_uncacheable | input | 1 | The request is uncacheable |
| upd_addr | input | ADDR_W | Byte start address of the request |
| upd_size | input | SIZE_W | Request size in bytes |
| qry_valid | input | 1 | Hold query from the miss queue |
| qry_line | input | ADDR_W-log2(LINE_BYTES) | Line address being queried |
| qry_size | input | SIZE_W | Size of the queued write |
| qry_full_line | input | 1 | The queued write covers a whole line |
| mode_o | output | 2 | Current mode code |
| coalesce | output | 1 | Coalescing requested |
| allocate | output | 1 | Whole-line write fills should allocate |
| qry_hold | output | 1 | Hold the queried write back |
| qry_hold_cycles | output | log2(LINE_BYTES)+1 | Suggested hold length in cycles |

## Verification
The properties assume that reset is asserted from time zero and that the inputs are stable around the clock edge. Both assumptions hold because the bench changes inputs only on the falling edge. The block is exercised only with non-zero request sizes, because a zero-size contiguous write would leave the next address unchanged. The properties that cover update acceptance rely on the precedence rule. For that reason the stimulus includes cycles where a query or a reset request lands together with an update, so that the dropped-update path is covered. Query and write sizes are powers of two no larger than a line, which keeps the hold-length quotient exact.

// File: rtl/swmd_pkg.sv
package swmd_pkg;

    typedef enum logic [1:0] {
        WM_ALLOC   = 2'd0,
        WM_COAL    = 2'd1,
        WM_NOALLOC = 2'd2
    } wmode_e;

    typedef enum logic [1:0] {
        CR_NONE  = 2'd0,
        CR_LOAD  = 2'd1,
        CR_CLEAR = 2'd2,
        CR_DEC   = 2'd3
    } cred_op_e;

    function automatic logic mode_coalesces(wmode_e m);
        return m != WM_ALLOC;
    endfunction

endpackage

// File: rtl/swmd_stream_fsm.sv
module swmd_stream_fsm
    import swmd_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 8,
    parameter int CNT_W         = 16,
    parameter int COAL_LIMIT    = 128,
    parameter int NOALLOC_LIMIT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output wmode_e            mode,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [ADDR_W-1:0] next_addr,
    output logic              contig
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat_cnt;

    assign contig  = (addr == next_addr);
    assign sum     = {1'b0, byte_cnt} + (CNT_W+1)'(size);
    assign sat_cnt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode      <= WM_ALLOC;
            byte_cnt  <= '0;
            next_addr <= '0;
        end else if (upd) begin
            if (contig) begin
                if (mode != WM_NOALLOC) begin
                    byte_cnt <= sat_cnt;
                    if (mode == WM_ALLOC && sat_cnt > CNT_W'(COAL_LIMIT))
                        mode <= WM_COAL;
                    else if (mode == WM_COAL && sat_cnt > CNT_W'(NOALLOC_LIMIT))
                        mode <= WM_NOALLOC;
                end
            end else begin
                byte_cnt <= CNT_W'(size);
                mode     <= WM_ALLOC;
            end
            next_addr <= addr + ADDR_W'(size);
        end
    end
endmodule

// File: rtl/swmd_credit_table.sv
module swmd_credit_table
    import swmd_pkg::*;
#(
    parameter int LINE_W       = 26,
    parameter int DEPTH        = 4,
    parameter int DELAY_THRESH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cred_op_e          op,
    input  logic [LINE_W-1:0] op_line,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_credit
);
    localparam int CRED_W = $clog2(DELAY_THRESH + 1);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] tag;
        logic [CRED_W-1:0] cred;
    } cred_ent_t;

    cred_ent_t         tbl [DEPTH];
    logic [PTR_W-1:0]  oldest;
    logic [DEPTH-1:0]  look_hit;
    logic [DEPTH-1:0]  op_hit;
    logic [PTR_W-1:0]  op_idx;
    logic              op_found;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign look_hit[g] = tbl[g].vld && (tbl[g].tag == look_line) && (tbl[g].cred != '0);
        assign op_hit[g]   = tbl[g].vld && (tbl[g].tag == op_line);
    end

    assign look_credit = |look_hit;
    assign op_found    = |op_hit;

    always_comb begin
        op_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (op_hit[i]) op_idx = PTR_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oldest <= '0;
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else begin
            case (op)
                CR_LOAD: begin
                    if (op_found) begin
                        tbl[op_idx].cred <= CRED_W'(DELAY_THRESH);
                    end else begin
                        tbl[oldest] <= '{vld: 1'b1, tag: op_line, cred: CRED_W'(DELAY_THRESH)};
                        oldest <= (oldest == PTR_W'(DEPTH - 1)) ? '0 : oldest + 1'b1;
                    end
                end
                CR_CLEAR: if (op_found) tbl[op_idx].cred <= '0;
                CR_DEC:   if (op_found && tbl[op_idx].cred != '0)
                              tbl[op_idx].cred <= tbl[op_idx].cred - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/write_stream_detector.sv
module write_stream_detector
    import swmd_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 8,
    parameter int CNT_W         = 16,
    parameter int LINE_BYTES    = 64,
    parameter int COAL_LIMIT    = 128,
    parameter int NOALLOC_LIMIT = 512,
    parameter int DELAY_THRESH  = 4,
    parameter int TBL_DEPTH     = 4,
    localparam int LINE_SH      = $clog2(LINE_BYTES),
    localparam int LINE_W       = ADDR_W - LINE_SH,
    localparam int HOLD_W       = LINE_SH + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_reset_req,
    input  logic              upd_valid,
    input  logic              upd_is_write,
    input  logic              upd_uncacheable,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [SIZE_W-1:0] upd_size,
    input  logic              qry_valid,
    input  logic [LINE_W-1:0] qry_line,
    input  logic [SIZE_W-1:0] qry_size,
    input  logic              qry_full_line,
    output logic [1:0]        mode_o,
    output logic              coalesce,
    output logic              allocate,
    output logic              qry_hold,
    output logic [HOLD_W-1:0] qry_hold_cycles
);
    wmode_e            mode;
    logic [CNT_W-1:0]  byte_cnt;
    logic [ADDR_W-1:0] next_addr;
    logic              contig;
    logic              upd_ok;
    logic              qry_act;
    logic              qry_partial;
    logic              has_credit;
    logic              soft_clr;
    cred_op_e          cr_op;
    logic [LINE_W-1:0] cr_line;

    assign coalesce    = mode_coalesces(mode);
    assign allocate    = (mode != WM_NOALLOC);
    assign mode_o      = mode;

    assign upd_ok      = upd_valid && upd_is_write && !upd_uncacheable
                         && !qry_valid && !mode_reset_req;
    assign qry_act     = qry_valid && !mode_reset_req && coalesce;
    assign qry_partial = qry_act && !qry_full_line;
    assign qry_hold    = qry_partial && has_credit;
    assign soft_clr    = mode_reset_req || (qry_partial && !has_credit);

    assign qry_hold_cycles = (qry_size == '0) ? HOLD_W'(LINE_BYTES)
                           : HOLD_W'(32'(LINE_BYTES) / 32'(qry_size));

    always_comb begin
        cr_op   = CR_NONE;
        cr_line = qry_line;
        if (qry_act) begin
            if (qry_full_line)   cr_op = CR_CLEAR;
            else if (has_credit) cr_op = CR_DEC;
        end else if (upd_ok) begin
            cr_line = upd_addr[ADDR_W-1:LINE_SH];
            cr_op   = contig ? CR_LOAD : CR_CLEAR;
        end
    end

    swmd_stream_fsm #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
        .COAL_LIMIT(COAL_LIMIT), .NOALLOC_LIMIT(NOALLOC_LIMIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .clr(soft_clr), .upd(upd_ok),
        .addr(upd_addr), .size(upd_size),
        .mode(mode), .byte_cnt(byte_cnt), .next_addr(next_addr), .contig(contig)
    );

    swmd_credit_table #(
        .LINE_W(LINE_W), .DEPTH(TBL_DEPTH), .DELAY_THRESH(DELAY_THRESH)
    ) u_tbl (
        .clk(clk), .rst(rst), .op(cr_op), .op_line(cr_line),
        .look_line(qry_line), .look_credit(has_credit)
    );
endmodule

// File: rtl/swmd_checker.sv
module swmd_checker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_reset_req,
    input logic              upd_valid,
    input logic              upd_is_write,
    input logic              upd_uncacheable,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [SIZE_W-1:0] upd_size,
    input logic              qry_valid,
    input logic              upd_ok,
    input logic [1:0]        mode_o,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic [ADDR_W-1:0] next_addr,
    input logic              qry_hold,
    input logic [HOLD_W-1:0] qry_hold_cycles
);
    AST_RESET_REQ: assert property (@(posedge clk) disable iff (rst)
        mode_reset_req |=> (mode_o == 2'd0 && byte_cnt == '0 && next_addr == '0)); // R11

    AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
        upd_ok |=> next_addr == $past(ADDR_W'(upd_addr + ADDR_W'(upd_size)))); // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |=> (mode_o != 2'd2)); // R3

    AST_NOALLOC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (upd_ok && mode_o == 2'd2 && upd_addr == next_addr) |=> $stable(byte_cnt)); // R4

    AST_MODE_CODE: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3); // R5

    AST_IGNORED_REQ: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (!upd_is_write || upd_uncacheable) && !qry_valid && !mode_reset_req)
        |=> ($stable(next_addr) && $stable(byte_cnt) && $stable(mode_o))); // R10

    AST_IDLE_QUERY: assert property (@(posedge clk) disable iff (rst)
        (qry_valid && !mode_reset_req && mode_o == 2'd0)
        |=> ($stable(next_addr) && $stable(byte_cnt))); // R11

    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        qry_hold |-> qry_hold_cycles != '0); // R7
endmodule

bind write_stream_detector swmd_checker #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) u_chk (
    .clk(clk), .rst(rst), .mode_reset_req(mode_reset_req),
    .upd_valid(upd_valid), .upd_is_write(upd_is_write),
    .upd_uncacheable(upd_uncacheable), .upd_addr(upd_addr),
    .upd_size(upd_size), .qry_valid(qry_valid), .upd_ok(upd_ok),
    .mode_o(mode_o), .byte_cnt(byte_cnt), .next_addr(next_addr),
    .qry_hold(qry_hold), .qry_hold_cycles(qry_hold_cycles)
);

// File: tb/sim_write_stream_detector.sv
module sim_write_stream_detector;
    localparam int LB     = 64;
    localparam int LSH    = 6;
    localparam int LW     = 32 - LSH;
    localparam int THR    = 4;
    localparam int DEPTH  = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          rr = 0, uv = 0, uw = 0, unc = 0, qv = 0, qf = 0;
    logic [31:0]   ua = '0;
    logic [7:0]    us = '0, qs = '0;
    logic [LW-1:0] ql = '0;
    logic [1:0]    mode_o;
    logic          coalesce, allocate, qry_hold;
    logic [6:0]    qry_hold_cycles;

    write_stream_detector u0 (
        .clk(clk), .rst(rst), .mode_reset_req(rr),
        .upd_valid(uv), .upd_is_write(uw), .upd_uncacheable(unc),
        .upd_addr(ua), .upd_size(us),
        .qry_valid(qv), .qry_line(ql), .qry_size(qs), .qry_full_line(qf),
        .mode_o(mode_o), .coalesce(coalesce), .allocate(allocate),
        .qry_hold(qry_hold), .qry_hold_cycles(qry_hold_cycles)
    );

    // behavioural reference
    typedef struct { longint line; int cred; } ent_t;
    ent_t   m_tab[$];
    int     m_mode;
    longint m_cnt;
    longint m_next;
    int     n_chk = 0, n_bad = 0;

    function automatic int find_line(longint line);
        foreach (m_tab[i]) if (m_tab[i].line == line) return i;
        return -1;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int  idx;
        bit  coal, hold;
        coal = (m_mode != 0);
        idx  = find_line(longint'(ql));
        hold = !rr && qv && coal && !qf && idx >= 0 && m_tab[idx].cred > 0;
        chk(tag, "mode", mode_o, m_mode);
        chk(tag, "coalesce", coalesce, coal);
        chk(tag, "allocate", allocate, m_mode != 2);
        chk(tag, "hold", qry_hold, hold);
        chk(tag, "hold_cycles", qry_hold_cycles, (qs == 0) ? LB : LB / qs);
    endtask

    task automatic model_apply();
        int     idx;
        longint line;
        if (rr) begin
            m_mode = 0; m_cnt = 0; m_next = 0;
            return;
        end
        if (qv) begin
            if (m_mode != 0) begin
                idx = find_line(longint'(ql));
                if (qf) begin
                    if (idx >= 0) m_tab[idx].cred = 0;
                end else if (idx >= 0 && m_tab[idx].cred > 0) begin
                    m_tab[idx].cred--;
                end else begin
                    m_mode = 0; m_cnt = 0; m_next = 0;
                end
            end
            return;
        end
        if (uv && uw && !unc) begin
            line = longint'(ua) >> LSH;
            idx  = find_line(line);
            if (longint'(ua) == m_next) begin
                if (idx >= 0) m_tab[idx].cred = THR;
                else begin
                    if (m_tab.size() == DEPTH) void'(m_tab.pop_front());
                    m_tab.push_back('{line, THR});
                end
                if (m_mode != 2) begin
                    m_cnt = m_cnt + us;
                    if (m_cnt > 65535) m_cnt = 65535;
                    if (m_mode == 0 && m_cnt > 128) m_mode = 1;
                    else if (m_mode == 1 && m_cnt > 512) m_mode = 2;
                end
            end else begin
                m_cnt = us; m_mode = 0;
                if (idx >= 0) m_tab[idx].cred = 0;
            end
            m_next = (longint'(ua) + us) & 64'hFFFF_FFFF;
        end
    endtask

    task automatic tick(bit r, bit v, bit w, bit u, logic [31:0] a, logic [7:0] s,
                        bit q, logic [LW-1:0] l, logic [7:0] qsz, bit f, string tag);
        @(negedge clk);
        rr = r; uv = v; uw = w; unc = u; ua = a; us = s;
        qv = q; ql = l; qs = qsz; qf = f;
        #1 compare(tag);
        @(posedge clk);
        model_apply();
    endtask

    task automatic wr(logic [31:0] a, logic [7:0] s, string tag);
        tick(0, 1, 1, 0, a, s, 0, '0, 8'd16, 0, tag);
    endtask

    task automatic qry(logic [LW-1:0] l, logic [7:0] s, bit f, string tag);
        tick(0, 0, 0, 0, '0, 8'd0, 1, l, s, f, tag);
    endtask

    task automatic idle(string tag);
        tick(0, 0, 0, 0, '0, 8'd0, 0, '0, 8'd16, 0, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        m_mode = 0; m_cnt = 0; m_next = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle("R1_reset");

        // R2 R3: 16-byte stream from 0x1000 crosses both limits
        for (int i = 0; i < 40; i++) wr(32'h1000 + 32'(i * 16), 8'd16, "R2_R3_stream");
        idle("R5_noalloc_outputs");
        wr(32'h1000 + 32'd640, 8'd16, "R4_frozen_count");

        // R10: ignored requests in no-allocate mode
        tick(0, 1, 1, 1, 32'h9000, 8'd4, 0, '0, 8'd16, 0, "R10_uncacheable");
        tick(0, 1, 0, 0, 32'h9100, 8'd4, 0, '0, 8'd16, 0, "R10_read");
        idle("R10_after");

        // R7 R8: credit of last streamed line drains, then resets
        for (int i = 0; i < THR + 1; i++) qry(LW'((32'h1000 + 32'd656 - 32'd16) >> LSH), 8'd16, 0, "R7_R8_drain");
        idle("R8_back_to_alloc");

        // R11: query while not coalescing changes nothing and drops update
        wr(32'h4000, 8'd32, "R2_restart");
        tick(0, 1, 1, 0, 32'h4020, 8'd32, 1, LW'(32'h100), 8'd8, 0, "R11_query_drops_update");
        wr(32'h4020, 8'd32, "R11_next_unchanged");
        tick(1, 1, 1, 0, 32'h4040, 8'd32, 0, '0, 8'd16, 0, "R11_reset_req");
        wr(32'h4040, 8'd32, "R11_after_reset_req");

        // R9: whole-line query clears credit
        wr(32'h20000, 8'd16, "R9_setup");
        for (int i = 1; i < 10; i++) wr(32'h20000 + 32'(i * 16), 8'd16, "R9_setup");
        qry(LW'(32'h20040 >> LSH), 8'd64, 1, "R9_full_line");
        qry(LW'(32'h20040 >> LSH), 8'd16, 0, "R9_no_credit_left");
        idle("R9_after");

        // R6 R12: 64-byte writes over five lines evict the earliest
        wr(32'h40000, 8'd64, "R12_setup");
        for (int i = 1; i < 6; i++) wr(32'h40000 + 32'(i * 64), 8'd64, "R6_R12_load");
        qry(LW'(32'h40140 >> LSH), 8'd8, 0, "R7_hold_len8");
        tick(1, 0, 0, 0, '0, 8'd0, 1, LW'(32'h40140 >> LSH), 8'd8, 0, "R11_reset_masks_hold");
        wr(32'h50000, 8'd64, "R12_setup2");
        for (int i = 1; i < 4; i++) wr(32'h50000 + 32'(i * 64), 8'd64, "R12_setup2");
        qry(LW'(32'h40040 >> LSH), 8'd32, 0, "R12_evicted_line");
        idle("R12_after");

        // R6: non-contiguous write clears its line credit
        wr(32'h60000, 8'd64, "R6_setup");
        for (int i = 1; i < 4; i++) wr(32'h60000 + 32'(i * 64), 8'd64, "R6_setup");
        wr(32'h600C0, 8'd8, "R6_noncontig_clear");
        for (int i = 1; i < 3; i++) wr(32'h600C0 + 32'(i * 64), 8'd64, "R6_setup");
        wr(32'h600C8 + 32'd128, 8'd64, "R6_setup");
        wr(32'h600C8 + 32'd192, 8'd64, "R6_setup");
        qry(LW'(32'h600C0 >> LSH), 8'd16, 0, "R6_cleared_line");
        idle("R6_after");

        summary();
    end
endmodule